// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM burst. A read or write command hands it a starting column, and from the next clock on it presents one column address per cycle. It follows the programmed burst length and beat order, and it marks the final beat. Apart from the start column and an optional stop pulse, it needs no further external input while the burst runs. Burst length and order come in as static mode settings. They are captured when a burst starts, so a change during a burst only takes effect at the next start.

A new start column is accepted on every cycle, including in the middle of a running burst. This supports random column access: each new column restarts the sequence from beat zero. A full-page setting walks every column with wrap-around and stops only when a stop request arrives or a new burst starts.

The address output is a stream with a valid flag and no ready. It cannot apply back-pressure, because SDRAM timing does not allow a burst to pause. The consumer must take one beat on every cycle in which `col_valid` is high. `col_addr` is meaningful only while `col_valid` is high.

Top module: `sdr_burst_col_gen`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `busy` are low until the first start.
- R2: A cycle with `start_valid` high is followed, on the next cycle, by `col_valid` high with `col_addr` equal to that `start_col`. This holds on any cycle, also mid-burst, and the sequence restarts from beat zero.
- R3: `cfg_burst_len` selects the length. 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. Codes 3'b100 to 3'b110 act as 1 beat. A fixed burst presents exactly that many consecutive beats, one per clock, after which `col_valid` falls.
- R4: With `cfg_interleave` low, beat i keeps the start column's bits above log2(BL). Its low log2(BL) bits equal (start low bits + i) mod BL.
- R5: With `cfg_interleave` high and a fixed length, beat i keeps the upper bits. Its low log2(BL) bits equal the start low bits XOR i.
- R6: In full page, the address rises by one each beat and wraps from 255 to 0. The burst never ends by itself, and `cfg_interleave` has no effect.
- R7: `col_last` is high only on the final beat of a fixed-length burst. It is never high in full page.
- R8: `busy` is high exactly on the beats that will be followed by another beat of the same burst. That is every valid beat except the final one.
- R9: `stop` high without `start_valid` makes `col_valid` low on the next cycle. When both are high, the start wins. `stop` while idle has no effect.
- R10: Length and order are captured at the start. Changing `cfg_burst_len` or `cfg_interleave` during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code (see R3) |
| cfg_interleave | input | 1 | 1 selects interleaved beat order |
| start_valid | input | 1 | Start a burst at `start_col` |
| start_col | input | COL_W (8) | Starting column |
| stop | input | 1 | Terminate the running burst |
| col_valid | output | 1 | A column beat is presented |
| col_addr | output | COL_W (8) | Column address of the current beat |
| col_last | output | 1 | Current beat is the final beat of a fixed burst |
| busy | output | 1 | More beats of this burst follow |

## Verification
Every cycle, the in-line assertions check several local rules. A start produces its own column on the next beat. A stop with no start empties the stream, and a final beat is followed by silence. A full-page beat with no interruption is followed by its successor address. `col_last` and `busy` never appear without a valid beat. Only the bench's reference model can show that the sequential and interleaved orders are correct for every length, and that the reserved codes act as one beat. It also shows that a configuration change mid-burst is ignored and that random restarts and stops land on the right beat.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;

  // Burst length codes; values are part of the block's interface.
  typedef enum logic [2:0] {
    BLEN_1    = 3'b000,
    BLEN_2    = 3'b001,
    BLEN_4    = 3'b010,
    BLEN_8    = 3'b011,
    BLEN_PAGE = 3'b111
  } blen_code_e;

  localparam int unsigned BLEN_CODE_W = 3;
  localparam int unsigned MAX_FIXED_LOG2 = 3;

  // log2 of the fixed burst length; reserved codes fall back to one beat.
  function automatic int unsigned blen_log2(input logic [BLEN_CODE_W-1:0] code);
    int unsigned r;
    if (code <= 3'(MAX_FIXED_LOG2)) r = int'(code);
    else                            r = 0;
    return r;
  endfunction

endpackage

// File: rtl/sdr_blen_decode.sv
module sdr_blen_decode
  import sdr_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [BLEN_CODE_W-1:0] code,
  input  logic                   ilv_in,
  output logic [COL_W-1:0]       wrap_mask,
  output logic                   full_page,
  output logic                   ilv_out
);

  int unsigned lg;

  always_comb begin
    full_page = (code == BLEN_PAGE);
    lg        = blen_log2(code);
    ilv_out   = ilv_in & ~full_page;
  end

  // One mask bit per column bit: set when the bit belongs to the wrapping field.
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign wrap_mask[b] = full_page | (lg > b);
  end

endmodule

// File: rtl/sdr_beat_ctrl.sv
module sdr_beat_ctrl #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             ilv_in,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base_col,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output logic             ilv_q,
  output logic             at_end
);

  assign at_end = ~full_q & (beat == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat     <= '0;
      base_col <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (start_valid) begin
      active   <= 1'b1;
      beat     <= '0;
      base_col <= start_col;
      mask_q   <= mask_in;
      full_q   <= full_in;
      ilv_q    <= ilv_in;
    end else if (stop) begin
      active   <= 1'b0;
    end else if (active) begin
      if (at_end) active <= 1'b0;
      else        beat   <= beat + COL_W'(1);
    end
  end

  // R6
  full_page_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && full_q && !start_valid && !stop) |=> active);

  // R10
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start_valid) |=> ($stable(mask_q) && $stable(ilv_q) && $stable(full_q)));

endmodule

// File: rtl/sdr_col_mix.sv
module sdr_col_mix #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_sum;
  assign seq_sum = base_col + beat;

  // Bits inside the wrap field take the ordered value, the rest keep the start column.
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? (ilv ? (base_col[b] ^ beat[b]) : seq_sum[b])
                            : base_col[b];
  end

endmodule

// File: rtl/sdr_burst_col_gen.sv
module sdr_burst_col_gen
  import sdr_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BLEN_CODE_W-1:0] cfg_burst_len,
  input  logic                   cfg_interleave,
  input  logic                   start_valid,
  input  logic [COL_W-1:0]       start_col,
  input  logic                   stop,
  output logic                   col_valid,
  output logic [COL_W-1:0]       col_addr,
  output logic                   col_last,
  output logic                   busy
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ilv;
  logic             active;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic             at_end;

  sdr_blen_decode #(.COL_W(COL_W)) u_decode (
    .code      (cfg_burst_len),
    .ilv_in    (cfg_interleave),
    .wrap_mask (dec_mask),
    .full_page (dec_full),
    .ilv_out   (dec_ilv)
  );

  sdr_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_col   (start_col),
    .stop        (stop),
    .mask_in     (dec_mask),
    .full_in     (dec_full),
    .ilv_in      (dec_ilv),
    .active      (active),
    .beat        (beat),
    .base_col    (base_col),
    .mask_q      (mask_q),
    .full_q      (full_q),
    .ilv_q       (ilv_q),
    .at_end      (at_end)
  );

  sdr_col_mix #(.COL_W(COL_W)) u_mix (
    .base_col (base_col),
    .beat     (beat),
    .mask     (mask_q),
    .ilv      (ilv_q),
    .col      (col_addr)
  );

  assign col_valid = active;
  assign col_last  = active & at_end;
  assign busy      = active & ~at_end;

  // R2
  start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |=> (col_valid && col_addr == $past(start_col)));

  // R9
  stop_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start_valid) |=> !col_valid);

  // R3
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start_valid) |=> !col_valid);

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> (col_valid && !full_q));

  // R8
  busy_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_valid && !stop) |=> (col_valid && !$rose(col_valid)));

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full_q && !start_valid && !stop) |=> (col_addr == $past(col_addr) + COL_W'(1)));

endmodule

// File: tb/sdr_burst_col_gen_tb.sv
module sdr_burst_col_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cfg_burst_len = 3'b000;
  logic             cfg_interleave = 1'b0;
  logic             start_valid = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             stop = 1'b0;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;
  logic             busy;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  // Reference model state
  int  r_active = 0;
  int  r_base = 0;
  int  r_beat = 0;
  int  r_len = 1;   // 0 means full page
  int  r_ilv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_burst_col_gen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .start_valid(start_valid), .start_col(start_col), .stop(stop),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last), .busy(busy)
  );

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int ref_addr();
    int bl, lo, hi;
    if (r_len == 0) return (r_base + r_beat) % 256;
    bl = r_len;
    lo = r_base % bl;
    hi = r_base - lo;
    if (r_ilv != 0) return hi + (lo ^ r_beat);
    return hi + ((lo + r_beat) % bl);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  // Reference model advances on the same edge as the design.
  always @(posedge clk) begin
    if (!rst_n) r_active = 0;
    else if (start_valid) begin
      r_active = 1; r_base = int'(start_col); r_beat = 0;
      r_len = code_len(cfg_burst_len);  // R10: captured here only
      r_ilv = (r_len != 0) ? int'(cfg_interleave) : 0;
    end else if (stop) r_active = 0;
    else if (r_active != 0) begin
      if (r_len != 0 && r_beat == r_len - 1) r_active = 0;
      else r_beat = (r_beat + 1) % 256;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    int e_last;
    cycles++;
    if (rst_n) begin
      e_last = (r_active != 0 && r_len != 0 && r_beat == r_len - 1) ? 1 : 0;
      check("R3 valid", int'(col_valid), r_active);
      if (r_active != 0)
        check(r_len == 0 ? "R6 addr" : (r_ilv != 0 ? "R5 addr" : "R4 addr"),
              int'(col_addr), ref_addr());
      check("R7 last", int'(col_last), e_last);
      check("R8 busy", int'(busy), (r_active != 0 && e_last == 0) ? 1 : 0);
    end
    if (cycles > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_valid = 1'b0; stop = 1'b0;
    end
  endtask

  task automatic go(input int col, input logic [2:0] bl, input logic ilv);
    @(negedge clk);
    start_valid = 1'b1; stop = 1'b0;
    start_col = COL_W'(col); cfg_burst_len = bl; cfg_interleave = ilv;
  endtask

  task automatic halt();
    @(negedge clk);
    start_valid = 1'b0; stop = 1'b1;
  endtask

  initial begin
    idle(3);
    // R1: outputs quiet in and right after reset
    check("R1 valid", int'(col_valid), 0);
    check("R1 last", int'(col_last), 0);
    check("R1 busy", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R1 valid idle", int'(col_valid), 0);

    // R4: sequential, every fixed length
    for (int c = 0; c < 4; c++) begin go(8'h3D, 3'(c), 1'b0); idle(10); end
    go(8'hF6, 3'b011, 1'b0); idle(10);
    // R5: interleaved, every fixed length
    for (int c = 0; c < 4; c++) begin go(8'hA7, 3'(c), 1'b1); idle(10); end
    go(8'h12, 3'b011, 1'b1); idle(10);
    // R3: reserved codes act as a single beat
    go(8'h55, 3'b101, 1'b0); idle(3);
    go(8'h56, 3'b100, 1'b1); idle(3);
    // R6: full page wraps, interleave ignored, then stop (R9)
    go(8'hFC, 3'b111, 1'b1); idle(12);
    check("R6 still running", int'(col_valid), 1);
    halt(); idle(1);
    check("R9 stopped", int'(col_valid), 0);
    idle(2);
    // R2: restart mid-burst
    go(8'h20, 3'b011, 1'b0); idle(2);
    go(8'h47, 3'b010, 1'b1); idle(1);
    check("R2 restart addr", int'(col_addr), 8'h47);
    idle(6);
    // R2: new column on every cycle
    for (int k = 0; k < 6; k++) go(k * 37, 3'b011, 1'b0);
    idle(10);
    // R9: stop while idle, start and stop together
    halt(); idle(1);
    check("R9 idle stop", int'(col_valid), 0);
    @(negedge clk);
    start_valid = 1'b1; stop = 1'b1; start_col = 8'h90; cfg_burst_len = 3'b010; cfg_interleave = 1'b0;
    idle(1);
    check("R9 start wins", int'(col_valid), 1);
    idle(6);
    // R10: configuration changes mid-burst
    go(8'h0B, 3'b011, 1'b0);
    @(negedge clk); start_valid = 1'b0; cfg_burst_len = 3'b000; cfg_interleave = 1'b1;
    idle(4);
    check("R10 burst kept", int'(col_valid), 1);
    idle(8);
    // Random mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      @(negedge clk);
      r = int'($urandom_range(0, 99));
      start_valid = (r < 30);
      stop = (r >= 30 && r < 38) || (r > 95);
      start_col = COL_W'($urandom);
      case ($urandom_range(0, 5))
        0: cfg_burst_len = 3'b000;
        1: cfg_burst_len = 3'b001;
        2: cfg_burst_len = 3'b010;
        3: cfg_burst_len = 3'b011;
        4: cfg_burst_len = 3'b111;
        default: cfg_burst_len = 3'b110;
      endcase
      cfg_interleave = 1'($urandom);
    end
    idle(12);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule